// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (I2C-style clock and open-drain data) and holds an 8192-byte memory. A master selects it with a device-select byte and sends a 13-bit word address as two bytes, high byte first. It can then write one byte or a page of up to 32 bytes, or read bytes one after another. After a write, a self-timed program cycle runs for a set number of system-clock cycles. For that whole time the block ignores the bus.

Both bus lines are sampled in a fast system-clock domain and then edge-detected. The data line is driven low only through an output-enable, and the line is pulled high outside the block. A single protect input freezes the whole array. Three select pins let up to eight of these blocks share one bus.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and no program cycle is running. A matching device-select byte is acknowledged.
- R2: The device-select byte has the type code 4'b1010 in bits 7:4, the select pins in bits 3:1 and the direction in bit 0 (1 = read). The block acknowledges only when both the type code and the pins match. On any mismatch it stays silent until the next START.
- R3: Two address bytes follow a write select, high byte first, and both are acknowledged. Only the low 5 bits of the high byte are used; bits 7:5 are ignored.
- R4: Each data byte of a write is acknowledged and placed at the current address. Then only the low 5 address bits advance, wrapping within the 32-byte page while the upper 8 bits stay fixed. A later byte that reaches the same page slot replaces the earlier one.
- R5: A program cycle starts only when a STOP ends a write that carried at least one data byte. A write with no data bytes only sets the address pointer. A repeated START after data bytes discards them and the memory is unchanged.
- R6: The program cycle lasts TWR_CYC system clocks. During it `sda_oe` stays 0 and the device select is not acknowledged. After it ends the block acknowledges again.
- R7: When `wp_i` is 1 at the STOP, no program cycle starts and the memory is unchanged. Select, address and data bytes are still acknowledged.
- R8: A read select with no address returns the byte at the current pointer. Every byte sent out advances the pointer by one.
- R9: A write select and two address bytes, followed by a repeated START and a read select, return data starting at that address.
- R10: A sequential read continues while the master acknowledges. The pointer wraps from 8191 to 0. The read ends on a master no-acknowledge and the block releases the line.
- R11: `sda_oe` changes only after a falling SCL, so read data and acknowledge bits stay stable while SCL is high.
- R12: A START at any point returns the block to device-select reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel_i | input | 3 | Strapped device-select pins |
| wp_i | input | 1 | 1 protects the whole array from writes |

## Verification
Two events can land almost on top of each other: the STOP that ends a write and starts the program cycle, and a new START with a device select sent right after it. The bench issues that select within a few bit times of the STOP and expects silence on the acknowledge bit. It repeats the same sequence with protect high and then expects an acknowledge, because no cycle may have started. A second collision is a repeated START just after data bytes have been accepted. There the bench reads the advanced pointer back and confirms that the old memory content survives.

// File: rtl/twm_pkg.sv
// Shared types and constants for the two-wire memory slave.
package twm_pkg;
    // Byte-level protocol states of the slave.
    typedef enum logic [2:0] {
        S_IDLE,   // not addressed, waiting for START
        S_DEV,    // receiving device-select byte
        S_AHI,    // receiving high address byte
        S_ALO,    // receiving low address byte
        S_WDAT,   // receiving write data bytes
        S_RDAT,   // shifting a read byte out
        S_RACK    // waiting for master acknowledge after a read byte
    } twm_state_e;

    // Fixed device-type code in the upper nibble of the select byte.
    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twm_line_watch.sv
// Synchronizes SCL/SDA into the system clock and decodes edges, START and STOP.
// Assumes the system clock is many times faster than SCL; both lines idle high.
module twm_line_watch #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [SYNC_N:0] scl_p;
    logic [SYNC_N:0] sda_p;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[SYNC_N-1:0], scl_i};
            sda_p <= {sda_p[SYNC_N-1:0], sda_i};
        end
    end

    assign sda_s    = sda_p[SYNC_N-1];
    assign scl_rise =  scl_p[SYNC_N-1] & ~scl_p[SYNC_N];
    assign scl_fall = ~scl_p[SYNC_N-1] &  scl_p[SYNC_N];
    assign ev_start = scl_p[SYNC_N-1] & scl_p[SYNC_N] & sda_p[SYNC_N] & ~sda_p[SYNC_N-1];
    assign ev_stop  = scl_p[SYNC_N-1] & scl_p[SYNC_N] & ~sda_p[SYNC_N] & sda_p[SYNC_N-1];
endmodule

// File: rtl/twm_prog_timer.sv
// Self-timed program cycle: busy for TWR_CYC clocks after a go pulse.
// The first PAGE_BYTES cycles also step a commit index over the page buffer.
// Assumes TWR_CYC > PAGE_BYTES; a go while busy is ignored.
module twm_prog_timer #(
    parameter int TWR_CYC = 300000,
    parameter int PAGE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              busy,
    output logic              commit_en,
    output logic [PAGE_W-1:0] commit_idx
);
    localparam int CW         = $clog2(TWR_CYC + 1);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [CW-1:0] left;

    // Load the cycle length on go and count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                  left <= '0;
        else if (go && left == '0)   left <= CW'(TWR_CYC);
        else if (left != '0)         left <= left - 1'b1;
    end

    assign busy       = (left != '0);
    assign commit_en  = busy && (left > CW'(TWR_CYC - PAGE_BYTES));
    assign commit_idx = PAGE_W'(CW'(TWR_CYC) - left);
endmodule

// File: rtl/twm_store.sv
// Byte array plus a one-page write buffer with per-slot valid bits.
// Buffer slots are committed one per cycle while commit_en is high.
// Array contents are not reset; read port is combinational.
module twm_store #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_clear,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     commit_en,
    input  logic [PAGE_W-1:0]        commit_idx,
    input  logic [ADDR_W-PAGE_W-1:0] page_sel,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pval;

    // Track which page-buffer slots hold data for this write.
    always_ff @(posedge clk) begin
        if (!rst_n || buf_clear) pval <= '0;
        else if (buf_we)         pval[buf_idx] <= 1'b1;
    end

    // Capture incoming data bytes into the page buffer.
    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    // Program one valid buffer slot per cycle into the array.
    always_ff @(posedge clk) begin
        if (commit_en && pval[commit_idx]) mem[{page_sel, commit_idx}] <= pbuf[commit_idx];
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/serial_eeprom_slave.sv
// Two-wire bus slave fronting a byte memory with page writes and sequential reads.
// Assumes a system clock fast enough to see every SCL phase after synchronizing;
// SDA is open-drain (sda_oe=1 pulls low). Bus is ignored during a program cycle.
module serial_eeprom_slave #(
    parameter int ADDR_W  = 13,
    parameter int PAGE_W  = 5,
    parameter int TWR_CYC = 300000,
    parameter int SYNC_N  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_i
);
    import twm_pkg::*;

    localparam int HI_W = ADDR_W - 8;

    twm_state_e        st, nxt_st;
    logic [2:0]        bcnt;
    logic [6:0]        sh;
    logic [7:0]        tx;
    logic [ADDR_W-1:0] ptr;
    logic              ack_go, in_ack, rack_seen, have_data;
    logic              prog_go, buf_we, buf_clear;
    logic [PAGE_W-1:0] buf_idx;
    logic [7:0]        buf_data;

    logic              sda_s, scl_rise, scl_fall, ev_start, ev_stop;
    logic              busy, commit_en;
    logic [PAGE_W-1:0] commit_idx;
    logic [7:0]        rd_data;
    logic [7:0]        rx_byte;
    logic              dev_hit;

    twm_line_watch #(.SYNC_N(SYNC_N)) u_watch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop)
    );

    twm_prog_timer #(.TWR_CYC(TWR_CYC), .PAGE_W(PAGE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(prog_go), .busy(busy),
        .commit_en(commit_en), .commit_idx(commit_idx)
    );

    twm_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_data(buf_data), .commit_en(commit_en),
        .commit_idx(commit_idx), .page_sel(ptr[ADDR_W-1:PAGE_W]),
        .rd_addr(ptr), .rd_data(rd_data)
    );

    assign rx_byte = {sh, sda_s};
    assign dev_hit = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == dev_sel_i);

    // Byte/bit protocol engine: receive, acknowledge, transmit, pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;  nxt_st <= S_IDLE;  bcnt <= '0;  sh <= '0;  tx <= '0;
            ptr <= '0;  ack_go <= 1'b0;  in_ack <= 1'b0;  rack_seen <= 1'b0;
            have_data <= 1'b0;  sda_oe <= 1'b0;  prog_go <= 1'b0;  buf_we <= 1'b0;
            buf_clear <= 1'b0;  buf_idx <= '0;  buf_data <= '0;
        end else begin
            prog_go   <= 1'b0;
            buf_we    <= 1'b0;
            buf_clear <= 1'b0;
            if (busy) begin
                st <= S_IDLE;  sda_oe <= 1'b0;  ack_go <= 1'b0;  in_ack <= 1'b0;
            end else if (ev_stop) begin
                prog_go   <= (st == S_WDAT) && have_data && !wp_i;
                st        <= S_IDLE;  sda_oe <= 1'b0;  ack_go <= 1'b0;  in_ack <= 1'b0;
                have_data <= 1'b0;
            end else if (ev_start) begin
                st <= S_DEV;  bcnt <= '0;  ack_go <= 1'b0;  in_ack <= 1'b0;
                sda_oe <= 1'b0;  have_data <= 1'b0;  buf_clear <= 1'b1;
            end else begin
                case (st)
                    S_DEV, S_AHI, S_ALO, S_WDAT: begin
                        if (scl_rise && !ack_go && !in_ack) begin
                            sh   <= rx_byte[6:0];
                            bcnt <= bcnt + 1'b1;
                            if (bcnt == 3'd7) begin
                                ack_go <= 1'b1;
                                if (st == S_DEV) begin
                                    if (!dev_hit) begin
                                        st     <= S_IDLE;
                                        ack_go <= 1'b0;
                                    end else begin
                                        nxt_st <= rx_byte[0] ? S_RDAT : S_AHI;
                                    end
                                end else if (st == S_AHI) begin
                                    ptr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
                                    nxt_st          <= S_ALO;
                                end else if (st == S_ALO) begin
                                    ptr[7:0] <= rx_byte;
                                    nxt_st   <= S_WDAT;
                                end else begin
                                    buf_we    <= 1'b1;
                                    buf_idx   <= ptr[PAGE_W-1:0];
                                    buf_data  <= rx_byte;
                                    ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                                    have_data <= 1'b1;
                                    nxt_st    <= S_WDAT;
                                end
                            end
                        end else if (scl_fall && ack_go) begin
                            sda_oe <= 1'b1;  in_ack <= 1'b1;  ack_go <= 1'b0;
                        end else if (scl_fall && in_ack) begin
                            in_ack <= 1'b0;  sda_oe <= 1'b0;  bcnt <= '0;  st <= nxt_st;
                            if (nxt_st == S_RDAT) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 1'b1;
                            end
                        end
                    end
                    S_RDAT: begin
                        if (scl_rise) begin
                            bcnt <= bcnt + 1'b1;
                            if (bcnt == 3'd7) begin
                                st <= S_RACK;  rack_seen <= 1'b0;
                            end
                        end else if (scl_fall && bcnt != 3'd0) begin
                            sda_oe <= ~tx[3'd7 - bcnt];
                        end
                    end
                    S_RACK: begin
                        if (scl_fall && !rack_seen) begin
                            sda_oe <= 1'b0;
                        end else if (scl_rise) begin
                            rack_seen <= 1'b1;
                            if (sda_s) st <= S_IDLE;
                        end else if (scl_fall && rack_seen) begin
                            tx <= rd_data;  sda_oe <= ~rd_data[7];  ptr <= ptr + 1'b1;
                            rack_seen <= 1'b0;  bcnt <= '0;  st <= S_RDAT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/twm_chk.sv
// Protocol checker for serial_eeprom_slave, attached by bind below.
// Observes the data-line enable, program-cycle state and the byte engine.
module twm_chk #(
    parameter int PG_HI_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sda_oe,
    input logic               busy,
    input logic               ev_stop,
    input logic               scl_fall,
    input logic               wp_i,
    input logic               in_ack,
    input twm_pkg::twm_state_e st,
    input logic [PG_HI_W-1:0] ptr_hi
);
    import twm_pkg::*;

    // R6
    busy_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R5
    prog_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ev_stop, 2));

    // R7
    prog_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i, 2));

    // R11
    oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall));

    // R4
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WDAT && $past(st) == S_WDAT) |-> (ptr_hi == $past(ptr_hi)));

    // R2
    oe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (in_ack || st == S_RDAT || st == S_RACK));
endmodule

bind serial_eeprom_slave twm_chk #(.PG_HI_W(ADDR_W - PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .busy(busy), .ev_stop(ev_stop),
    .scl_fall(scl_fall), .wp_i(wp_i), .in_ack(in_ack), .st(st),
    .ptr_hi(ptr[ADDR_W-1:PAGE_W])
);

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;
    localparam int TWR   = 400;
    localparam int Q     = 4;
    localparam int DEPTH = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] pins = 3'b101;
    logic       sda_oe;
    logic       sda_line;

    assign sda_line = m_sda & ~sda_oe;
    always #10 clk = ~clk;

    serial_eeprom_slave #(.TWR_CYC(TWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .dev_sel_i(pins), .wp_i(wp)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] model [DEPTH];
    bit         known [DEPTH];
    int         mptr = 0;

    function automatic int page_next(input int p);
        return (p & ~31) | ((p + 1) & 31);
    endfunction

    function automatic int lin_next(input int p);
        return (p + 1) % DEPTH;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(2*Q);
        m_sda = 1'b0; tick(2*Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(2*Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit nack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_sda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
        end
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        nack = sda_line;
        tick(Q); scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mnack, output logic [7:0] b, output bit stable);
        logic first;
        stable = 1'b1;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2*Q); scl = 1'b1; tick(1); first = sda_line;
            tick(Q); b[i] = sda_line; tick(Q-1);
            if (sda_line != first) stable = 1'b0;
            scl = 1'b0;
        end
        tick(Q); m_sda = mnack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    endtask

    task automatic settle();
        tick(TWR + 40);
    endtask

    // Write transaction: addr is the raw 16-bit address sent on the bus.
    task automatic wr_tx(input int addr, input int n, input bit wpv, input string req);
        bit         nk;
        bit         ok = 1'b1;
        int         p;
        logic [7:0] d;
        logic [7:0] pb [32];
        bit         pv [32];
        for (int k = 0; k < 32; k++) pv[k] = 1'b0;
        wp = wpv;
        bus_start();
        send_byte({4'b1010, pins, 1'b0}, nk); ok &= !nk;
        send_byte(8'(addr >> 8), nk); ok &= !nk;
        send_byte(8'(addr), nk); ok &= !nk;
        p = addr & (DEPTH - 1);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom());
            send_byte(d, nk); ok &= !nk;
            pb[p & 31] = d; pv[p & 31] = 1'b1;
            p = page_next(p);
        end
        bus_stop();
        wp = 1'b0;
        chk(ok, req, ok, 1);
        if (n > 0 && !wpv)
            for (int k = 0; k < 32; k++)
                if (pv[k]) begin
                    model[(p & ~31) | k] = pb[k];
                    known[(p & ~31) | k] = 1'b1;
                end
        mptr = p;
    endtask

    // Read transaction: random (address set first) or current-address.
    task automatic rd_tx(input int addr, input bit cur, input int n, input string req);
        bit         nk;
        bit         ok = 1'b1;
        bit         stab;
        bit         all_stab = 1'b1;
        logic [7:0] b;
        bus_start();
        if (!cur) begin
            send_byte({4'b1010, pins, 1'b0}, nk); ok &= !nk;
            send_byte(8'(addr >> 8), nk); ok &= !nk;
            send_byte(8'(addr), nk); ok &= !nk;
            mptr = addr & (DEPTH - 1);
            bus_start();
        end
        send_byte({4'b1010, pins, 1'b1}, nk); ok &= !nk;
        chk(ok, req, ok, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b, stab);
            all_stab &= stab;
            if (known[mptr]) chk(b == model[mptr], req, b, model[mptr]);
            mptr = lin_next(mptr);
        end
        bus_stop();
        chk(all_stab, "R11", all_stab, 1);
        chk(sda_line == 1'b1, "R10", sda_line, 1);
    endtask

    initial begin
        bit         nk;
        logic [7:0] b;
        bit         stab;
        for (int k = 0; k < DEPTH; k++) known[k] = 1'b0;
        void'($urandom(32'd1977));
        tick(5); rst_n = 1'b1; tick(5);

        // R1: reset state and first select
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
        bus_start(); send_byte({4'b1010, pins, 1'b0}, nk); bus_stop();
        chk(nk == 1'b0, "R1", nk, 0);

        // R2: pin mismatch and type mismatch are not acknowledged
        bus_start(); send_byte({4'b1010, 3'b010, 1'b0}, nk); bus_stop();
        chk(nk == 1'b1, "R2", nk, 1);
        bus_start(); send_byte({4'b1011, pins, 1'b0}, nk); bus_stop();
        chk(nk == 1'b1, "R2", nk, 1);

        // R4 + R9: short page write, random read back
        wr_tx(16'h0100, 4, 1'b0, "R4"); settle();
        rd_tx(16'h0100, 1'b0, 4, "R9");

        // R3: upper three bits of address high byte ignored
        wr_tx(16'hE150, 3, 1'b0, "R3"); settle();
        rd_tx(16'h0150, 1'b0, 3, "R3");

        // R4: write wrapping inside the page, later bytes replace earlier slots
        wr_tx(16'h1F3C, 36, 1'b0, "R4"); settle();
        rd_tx(16'h1F20, 1'b0, 32, "R4");

        // R6: program cycle makes the block deaf right after STOP
        wr_tx(16'h0300, 2, 1'b0, "R5");
        bus_start(); send_byte({4'b1010, pins, 1'b0}, nk);
        chk(nk == 1'b1, "R6", nk, 1);
        chk(sda_line == 1'b1, "R6", sda_line, 1);
        bus_stop(); settle();
        bus_start(); send_byte({4'b1010, pins, 1'b0}, nk); bus_stop();
        chk(nk == 1'b0, "R6", nk, 0);
        rd_tx(16'h0300, 1'b0, 2, "R6");

        // R7: protected write is acknowledged, starts no cycle, changes nothing
        wr_tx(16'h0100, 4, 1'b1, "R7");
        bus_start(); send_byte({4'b1010, pins, 1'b0}, nk); bus_stop();
        chk(nk == 1'b0, "R7", nk, 0);
        rd_tx(16'h0100, 1'b0, 4, "R7");

        // R5: address-only write just loads the pointer; R8 current read
        wr_tx(16'h0102, 0, 1'b0, "R5");
        bus_start(); send_byte({4'b1010, pins, 1'b0}, nk); bus_stop();
        chk(nk == 1'b0, "R5", nk, 0);
        mptr = 16'h0102;
        rd_tx(0, 1'b1, 2, "R8");

        // R12 + R5: repeated START after data bytes aborts the write
        bus_start();
        send_byte({4'b1010, pins, 1'b0}, nk);
        send_byte(8'h01, nk); send_byte(8'h00, nk);
        send_byte(8'h5A, nk); send_byte(8'hA5, nk);
        bus_start();
        send_byte({4'b1010, pins, 1'b1}, nk);
        chk(nk == 1'b0, "R12", nk, 0);
        recv_byte(1'b1, b, stab);
        chk(b == model[16'h0102], "R12", b, model[16'h0102]);
        bus_stop();
        bus_start(); send_byte({4'b1010, pins, 1'b0}, nk); bus_stop();
        chk(nk == 1'b0, "R5", nk, 0);
        rd_tx(16'h0100, 1'b0, 4, "R5");

        // R10: sequential read wraps from the top address to zero
        wr_tx(8190, 2, 1'b0, "R10"); settle();
        wr_tx(0, 3, 1'b0, "R10"); settle();
        rd_tx(8190, 1'b0, 4, "R10");
        rd_tx(0, 1'b1, 1, "R8");

        // Constrained random mix of writes and reads
        for (int it = 0; it < 14; it++) begin
            int a  = $urandom_range(8191, 0);
            int n  = $urandom_range(34, 1);
            bit pw = ($urandom_range(3, 0) == 0);
            wr_tx(a, n, pw, pw ? "R7" : "R4"); settle();
            rd_tx((a & 8160) | $urandom_range(31, 0), 1'b0, $urandom_range(6, 1), "R9");
            if (it % 3 == 0) rd_tx(0, 1'b1, 3, "R8");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule